// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Compares

This block is a low-frequency real-time counter that sits on a simple 32-bit register bus. A 24-bit count advances once every P+1 cycles in which the slow-clock enable input is high. P is a 12-bit divide value. Software drives the block with write-one task strobes: run, halt, zero, and a preload to just below wrap. It reads the count, the divide value and four 24-bit compare values back over the same bus.

Every increment records a tick. A wrap from the all-ones value to zero records an overflow. An increment that lands on a compare value records a match for that channel. These records are sticky until software writes zero to them. One enable mask decides which pending records assert the single interrupt line. A second, independent mask decides which records also leave the block as one-cycle pulses on the routing outputs.

Top module: `slow_counter_unit`

## Requirements
- R1: After reset the counter is stopped and reads 0. All sticky events, both enable masks, the divide value and the compare values are zero. `irq` and `ev_out` are low.
- R2: While running, the counter advances by one on every (P+1)-th cycle with `slow_en` high. The divide phase restarts on the run task and on the zero task. Address 0x504 returns the count in bits 23:0 with bits 31:24 zero.
- R3: A bus write with wdata bit 0 set acts as a task. Address 0x000 runs the counter, 0x004 halts it and 0x008 zeroes it. A halted counter holds its value whatever `slow_en` does.
- R4: A task write to 0x00C loads 0xFFFFF0. An increment from 0xFFFFFF gives 0 and sets the overflow event, read at 0x104.
- R5: Every increment sets the tick event, read at 0x100. Compare channel n holds a 24-bit value at 0x540+4n. An increment whose new count equals that value sets the compare event at 0x140+4n. Zeroing or preloading the count sets no event.
- R6: An event register reads 1 while pending. Writing a word with bit 0 clear removes it. Writing bit 0 set leaves it unchanged.
- R7: Both enable masks use bit 0 for tick, bit 1 for overflow and bits 16..19 for compares 0..3. A write to 0x304 sets the interrupt enables whose bits are 1. A write to 0x308 clears them. Both addresses read the interrupt mask in that layout.
- R8: `irq` is high exactly when at least one pending event has its interrupt enable set.
- R9: The routing mask uses the same layout. 0x340 is written directly, 0x344 sets bits and 0x348 clears bits, and all three read the mask. `ev_out` bit order is tick, overflow, then compare 0..3. A bit pulses for one cycle, in the cycle its event becomes set, only when its routing enable is on.
- R10: The divide value at 0x508 is 12 bits. A write takes effect only while the counter is halted. Writes while it is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | Slow-clock enable; one prescaler step per high cycle |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| ev_out | output | 6 | One-cycle routed event pulses |

## Verification
The counting path is tried with a table of divide values and enable-run lengths. The run lengths sit below, at and well above whole multiples of P+1. This separates a correct divide-by-(P+1) from off-by-one dividers and from a divider that ignores P. A zero-then-restart pattern run in mid-phase tells a divider that restarts on the zero task from one that keeps its old phase. The preload pattern followed by sixteen increments separates a correct 24-bit wrap and overflow event from a counter that saturates or is wider. A compare run with routing enabled on only one channel shows that matches, pulses and interrupt gating each follow their own mask.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int CNT_W  = 24;
  localparam int PRE_W  = 12;
  localparam int N_CMP  = 4;
  localparam int N_SRC  = 2 + N_CMP;
  localparam int ADDR_W = 12;
  localparam int CMP_MASK_LSB = 16;

  // source indices inside the internal vectors
  localparam int SRC_TICK = 0;
  localparam int SRC_WRAP = 1;
  localparam int SRC_CMP0 = 2;

  localparam logic [ADDR_W-1:0] A_RUN      = 12'h000;
  localparam logic [ADDR_W-1:0] A_HALT     = 12'h004;
  localparam logic [ADDR_W-1:0] A_ZERO     = 12'h008;
  localparam logic [ADDR_W-1:0] A_PRELOAD  = 12'h00C;
  localparam logic [ADDR_W-1:0] A_EV_TICK  = 12'h100;
  localparam logic [ADDR_W-1:0] A_EV_WRAP  = 12'h104;
  localparam logic [ADDR_W-1:0] A_EV_CMP   = 12'h140;
  localparam logic [ADDR_W-1:0] A_IEN_SET  = 12'h304;
  localparam logic [ADDR_W-1:0] A_IEN_CLR  = 12'h308;
  localparam logic [ADDR_W-1:0] A_RTE      = 12'h340;
  localparam logic [ADDR_W-1:0] A_RTE_SET  = 12'h344;
  localparam logic [ADDR_W-1:0] A_RTE_CLR  = 12'h348;
  localparam logic [ADDR_W-1:0] A_COUNT    = 12'h504;
  localparam logic [ADDR_W-1:0] A_DIV      = 12'h508;
  localparam logic [ADDR_W-1:0] A_CMPVAL   = 12'h540;

  // address of compare value register n
  function automatic logic [ADDR_W-1:0] cmpval_addr(input int n);
    return A_CMPVAL + ADDR_W'(4 * n);
  endfunction

  // address of compare event register n
  function automatic logic [ADDR_W-1:0] cmpev_addr(input int n);
    return A_EV_CMP + ADDR_W'(4 * n);
  endfunction

  // internal source vector -> bus mask layout
  function automatic logic [31:0] src_to_mask(input logic [N_SRC-1:0] s);
    logic [31:0] m;
    m = '0;
    m[0] = s[SRC_TICK];
    m[1] = s[SRC_WRAP];
    for (int n = 0; n < N_CMP; n++) m[CMP_MASK_LSB + n] = s[SRC_CMP0 + n];
    return m;
  endfunction

  // bus mask layout -> internal source vector
  function automatic logic [N_SRC-1:0] mask_to_src(input logic [31:0] m);
    logic [N_SRC-1:0] s;
    s[SRC_TICK] = m[0];
    s[SRC_WRAP] = m[1];
    for (int n = 0; n < N_CMP; n++) s[SRC_CMP0 + n] = m[CMP_MASK_LSB + n];
    return s;
  endfunction

  // count after one increment, wrapping at the width
  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction
endpackage

// File: rtl/rtc_count_core.sv
module rtc_count_core
  import rtc_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_en,
  input  logic          do_run,
  input  logic          do_halt,
  input  logic          do_zero,
  input  logic          do_preload,
  input  logic          div_we,
  input  logic [PW-1:0] div_wd,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic [PW-1:0] div_val,
  output logic          running,
  output logic          task_any,
  output logic          inc_fire,
  output logic          wrap_fire
);
  localparam logic [CW-1:0] CNT_TOP    = '1;
  localparam logic [CW-1:0] NEAR_WRAP  = CNT_TOP - CW'(15);

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] phase_q;
  logic [PW-1:0] div_q;
  logic          run_q;
  logic          phase_done;
  logic          step_ok;

  assign task_any   = do_run | do_halt | do_zero | do_preload;
  assign phase_done = (phase_q == div_q);
  assign step_ok    = run_q && slow_en && !task_any;
  assign inc_fire   = step_ok && phase_done;
  assign cnt_nxt    = cnt_q + CW'(1);
  assign wrap_fire  = inc_fire && (cnt_q == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= '0;
      div_q   <= '0;
      run_q   <= 1'b0;
    end else begin
      if (do_run) begin
        run_q   <= 1'b1;
        phase_q <= '0;
      end else if (do_halt) begin
        run_q <= 1'b0;
      end

      if (do_zero) begin
        cnt_q   <= '0;
        phase_q <= '0;
      end else if (do_preload) begin
        cnt_q <= NEAR_WRAP;
      end else if (step_ok) begin
        if (phase_done) begin
          phase_q <= '0;
          cnt_q   <= cnt_nxt;
        end else begin
          phase_q <= phase_q + PW'(1);
        end
      end

      if (div_we && !run_q) div_q <= div_wd;
    end
  end

  assign cnt     = cnt_q;
  assign div_val = div_q;
  assign running = run_q;
endmodule

// File: rtl/rtc_cmp_bank.sv
module rtc_cmp_bank
  import rtc_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int NC = N_CMP
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NC-1:0]        val_we,
  input  logic [CW-1:0]        val_wd,
  input  logic                 inc_fire,
  input  logic [CW-1:0]        cnt_nxt,
  output logic [NC-1:0][CW-1:0] cmp_val,
  output logic [NC-1:0]        cmp_fire
);
  for (genvar n = 0; n < NC; n++) begin : g_ch
    logic [CW-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         val_q <= '0;
      else if (val_we[n]) val_q <= val_wd;
    end

    assign cmp_val[n]  = val_q;
    assign cmp_fire[n] = inc_fire && (cnt_nxt == val_q);
  end
endmodule

// File: rtl/rtc_evt_ctrl.sv
module rtc_evt_ctrl
  import rtc_pkg::*;
#(
  parameter int NS = N_SRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] hits,
  input  logic [NS-1:0] ev_clr,
  input  logic [NS-1:0] wr_src,
  input  logic          ien_set_we,
  input  logic          ien_clr_we,
  input  logic          rte_we,
  input  logic          rte_set_we,
  input  logic          rte_clr_we,
  output logic [NS-1:0] pend,
  output logic [NS-1:0] ien,
  output logic [NS-1:0] rte,
  output logic [NS-1:0] pulse,
  output logic          irq
);
  logic [NS-1:0] pend_q, ien_q, rte_q, pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      ien_q   <= '0;
      rte_q   <= '0;
      pulse_q <= '0;
    end else begin
      // a new hit wins over a software clear in the same cycle
      pend_q  <= (pend_q & ~ev_clr) | hits;
      pulse_q <= hits & rte_q;

      if (ien_set_we)      ien_q <= ien_q | wr_src;
      else if (ien_clr_we) ien_q <= ien_q & ~wr_src;

      if (rte_we)          rte_q <= wr_src;
      else if (rte_set_we) rte_q <= rte_q | wr_src;
      else if (rte_clr_we) rte_q <= rte_q & ~wr_src;
    end
  end

  assign pend  = pend_q;
  assign ien   = ien_q;
  assign rte   = rte_q;
  assign pulse = pulse_q;
  assign irq   = |(pend_q & ien_q);
endmodule

// File: rtl/slow_counter_unit.sv
module slow_counter_unit
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [N_SRC-1:0]  ev_out
);
  localparam int PAD_C = 32 - CNT_W;
  localparam int PAD_P = 32 - PRE_W;

  // named internal events, also used by the checker
  logic                       wr;
  logic                       do_run, do_halt, do_zero, do_preload;
  logic                       task_any;
  logic                       div_we;
  logic [CNT_W-1:0]           cnt_q;
  logic [CNT_W-1:0]           cnt_nxt;
  logic [PRE_W-1:0]           div_q;
  logic                       running;
  logic                       inc_fire;
  logic                       wrap_fire;
  logic [N_CMP-1:0]           cmp_fire;
  logic [N_CMP-1:0]           cmp_we;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_val;
  logic [N_SRC-1:0]           hits;
  logic [N_SRC-1:0]           ev_clr;
  logic [N_SRC-1:0]           wr_src;
  logic [N_SRC-1:0]           pend, ien, rte;

  assign wr         = bus_sel && bus_wr;
  assign do_run     = wr && bus_addr == A_RUN     && bus_wdata[0];
  assign do_halt    = wr && bus_addr == A_HALT    && bus_wdata[0];
  assign do_zero    = wr && bus_addr == A_ZERO    && bus_wdata[0];
  assign do_preload = wr && bus_addr == A_PRELOAD && bus_wdata[0];
  assign div_we     = wr && bus_addr == A_DIV;
  assign wr_src     = mask_to_src(bus_wdata);

  assign ev_clr[SRC_TICK] = wr && bus_addr == A_EV_TICK && !bus_wdata[0];
  assign ev_clr[SRC_WRAP] = wr && bus_addr == A_EV_WRAP && !bus_wdata[0];

  for (genvar n = 0; n < N_CMP; n++) begin : g_dec
    assign cmp_we[n]            = wr && bus_addr == cmpval_addr(n);
    assign ev_clr[SRC_CMP0 + n] = wr && bus_addr == cmpev_addr(n) && !bus_wdata[0];
  end

  rtc_count_core #(.CW(CNT_W), .PW(PRE_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .slow_en    (slow_en),
    .do_run     (do_run),
    .do_halt    (do_halt),
    .do_zero    (do_zero),
    .do_preload (do_preload),
    .div_we     (div_we),
    .div_wd     (bus_wdata[PRE_W-1:0]),
    .cnt        (cnt_q),
    .cnt_nxt    (cnt_nxt),
    .div_val    (div_q),
    .running    (running),
    .task_any   (task_any),
    .inc_fire   (inc_fire),
    .wrap_fire  (wrap_fire)
  );

  rtc_cmp_bank #(.CW(CNT_W), .NC(N_CMP)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .val_we   (cmp_we),
    .val_wd   (bus_wdata[CNT_W-1:0]),
    .inc_fire (inc_fire),
    .cnt_nxt  (cnt_nxt),
    .cmp_val  (cmp_val),
    .cmp_fire (cmp_fire)
  );

  assign hits = {cmp_fire, wrap_fire, inc_fire};

  rtc_evt_ctrl #(.NS(N_SRC)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .hits       (hits),
    .ev_clr     (ev_clr),
    .wr_src     (wr_src),
    .ien_set_we (wr && bus_addr == A_IEN_SET),
    .ien_clr_we (wr && bus_addr == A_IEN_CLR),
    .rte_we     (wr && bus_addr == A_RTE),
    .rte_set_we (wr && bus_addr == A_RTE_SET),
    .rte_clr_we (wr && bus_addr == A_RTE_CLR),
    .pend       (pend),
    .ien        (ien),
    .rte        (rte),
    .pulse      (ev_out),
    .irq        (irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_EV_TICK:             bus_rdata = {31'b0, pend[SRC_TICK]};
      A_EV_WRAP:             bus_rdata = {31'b0, pend[SRC_WRAP]};
      A_IEN_SET, A_IEN_CLR:  bus_rdata = src_to_mask(ien);
      A_RTE, A_RTE_SET,
      A_RTE_CLR:             bus_rdata = src_to_mask(rte);
      A_COUNT:               bus_rdata = {{PAD_C{1'b0}}, cnt_q};
      A_DIV:                 bus_rdata = {{PAD_P{1'b0}}, div_q};
      default:               bus_rdata = '0;
    endcase
    for (int n = 0; n < N_CMP; n++) begin
      if (bus_addr == cmpval_addr(n)) bus_rdata = {{PAD_C{1'b0}}, cmp_val[n]};
      if (bus_addr == cmpev_addr(n))  bus_rdata = {31'b0, pend[SRC_CMP0 + n]};
    end
  end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_q,
  input logic [PRE_W-1:0] div_q,
  input logic             running,
  input logic             task_any,
  input logic             inc_fire,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] ien,
  input logic [N_SRC-1:0] ev_out,
  input logic             irq
);
  // R2: an increment advances the count by exactly one (24-bit wrap)
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inc_fire |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R3: a halted counter with no task write keeps its value
  assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !task_any) |=> $stable(cnt_q));

  // R4: an increment from all-ones wraps to zero and flags overflow
  assert_wrap_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_fire && cnt_q == '1) |=> (cnt_q == '0 && pend[SRC_WRAP]));

  // R5: every increment leaves the tick event pending
  assert_tick_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_fire |=> pend[SRC_TICK]);

  // R8: no enabled source means no interrupt
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);

  // R9: a routed pulse only appears with its event pending
  assert_route_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_out != '0) |-> ((ev_out & ~pend) == '0));

  // R10: the divide value cannot change while running
  assert_div_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(div_q));
endmodule

bind slow_counter_unit rtc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_q    (cnt_q),
  .div_q    (div_q),
  .running  (running),
  .task_any (task_any),
  .inc_fire (inc_fire),
  .pend     (pend),
  .ien      (ien),
  .ev_out   (ev_out),
  .irq      (irq)
);

// File: tb/sim_slow_counter_unit.sv
module sim_slow_counter_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [5:0]  ev_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int pcnt [6];

  always #2 clk = ~clk; // 250 MHz

  slow_counter_unit u0 (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .ev_out(ev_out)
  );

  initial for (int k = 0; k < 6; k++) pcnt[k] = 0;
  always @(negedge clk) for (int k = 0; k < 6; k++) if (ev_out[k]) pcnt[k]++;

  // divide value, enabled cycles, expected count (= cycles / (div+1))
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{0, 10, 10}, '{1, 10, 5}, '{2, 10, 3},
    '{3, 7, 1},   '{4, 4, 0},  '{9, 30, 3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    slow_en = 1'b1;
    repeat (n) @(negedge clk);
    slow_en = 1'b0;
  endtask

  task automatic finish_up;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_up();
    end
  end

  initial begin
    logic [31:0] v;
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_reg(12'h504, v); chk("R1 counter", v, 32'h0);
    rd_reg(12'h304, v); chk("R1 int mask", v, 32'h0);
    rd_reg(12'h340, v); chk("R1 route mask", v, 32'h0);
    rd_reg(12'h508, v); chk("R1 divide", v, 32'h0);
    rd_reg(12'h100, v); chk("R1 tick ev", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 ev_out", {26'b0, ev_out}, 32'h0);

    // R2 vector table: divide by (div+1)
    for (int i = 0; i < NV; i++) begin
      wr_reg(12'h004, 1);
      wr_reg(12'h008, 1);
      wr_reg(12'h100, 0);
      wr_reg(12'h508, VEC[i][0]);
      wr_reg(12'h000, 1);
      run_ticks(VEC[i][1]);
      rd_reg(12'h504, v); chk($sformatf("R2 vec%0d count", i), v, VEC[i][2]);
      rd_reg(12'h100, v); chk($sformatf("R5 vec%0d tick ev", i), v, (VEC[i][2] > 0) ? 1 : 0);
    end

    // R10: divide value locked while running (still running, div 9)
    wr_reg(12'h508, 7);
    rd_reg(12'h508, v); chk("R10 write while running ignored", v, 9);

    // R3: halt holds the count
    wr_reg(12'h004, 1);
    run_ticks(25);
    rd_reg(12'h504, v); chk("R3 halted count held", v, 3);
    wr_reg(12'h508, 3);
    rd_reg(12'h508, v); chk("R10 write while halted", v, 3);

    // R2/R3: zero task restarts the divide phase
    wr_reg(12'h000, 1);
    run_ticks(3);
    wr_reg(12'h008, 1);
    rd_reg(12'h504, v); chk("R3 zero task", v, 0);
    run_ticks(3);
    rd_reg(12'h504, v); chk("R2 phase restart after zero", v, 0);
    run_ticks(1);
    rd_reg(12'h504, v); chk("R2 first step after zero", v, 1);

    // R7: enable mask layout and set/clear
    wr_reg(12'h304, 32'h000F0003);
    rd_reg(12'h304, v); chk("R7 int set", v, 32'h000F0003);
    wr_reg(12'h308, 32'h00010001);
    rd_reg(12'h308, v); chk("R7 int clr", v, 32'h000E0002);
    wr_reg(12'h308, 32'hFFFFFFFF);
    rd_reg(12'h304, v); chk("R7 int all clear", v, 32'h0);

    // R9: routing mask direct write, set, clear
    wr_reg(12'h340, 32'h00000003);
    rd_reg(12'h340, v); chk("R9 route direct", v, 32'h3);
    wr_reg(12'h348, 32'h00000001);
    rd_reg(12'h344, v); chk("R9 route clr", v, 32'h2);
    wr_reg(12'h340, 32'h0);

    // R4: preload and wrap
    wr_reg(12'h004, 1);
    wr_reg(12'h508, 0);
    wr_reg(12'h00C, 1);
    rd_reg(12'h504, v); chk("R4 preload value", v, 32'h00FFFFF0);
    wr_reg(12'h104, 0);
    wr_reg(12'h304, 32'h2);
    wr_reg(12'h000, 1);
    run_ticks(15);
    rd_reg(12'h504, v); chk("R4 at top", v, 32'h00FFFFFF);
    rd_reg(12'h104, v); chk("R4 no overflow yet", v, 0);
    chk("R8 irq low before wrap", {31'b0, irq}, 0);
    run_ticks(1);
    rd_reg(12'h504, v); chk("R4 wrapped to zero", v, 0);
    rd_reg(12'h104, v); chk("R4 overflow event", v, 1);
    chk("R8 irq on overflow", {31'b0, irq}, 1);
    wr_reg(12'h104, 0);
    rd_reg(12'h104, v); chk("R6 overflow cleared", v, 0);
    chk("R8 irq after clear", {31'b0, irq}, 0);

    // R5/R9: compare match with routing on channel 2 only
    wr_reg(12'h004, 1);
    wr_reg(12'h008, 1);
    for (int n = 0; n < 4; n++) wr_reg(12'h140 + 12'(4 * n), 0);
    wr_reg(12'h548, 5);
    wr_reg(12'h344, 32'h00040000);
    p0 = pcnt[4];
    wr_reg(12'h000, 1);
    run_ticks(8);
    wr_reg(12'h004, 1);
    rd_reg(12'h548, v); chk("R5 compare value", v, 5);
    rd_reg(12'h148, v); chk("R5 compare 2 event", v, 1);
    rd_reg(12'h144, v); chk("R5 compare 1 no event", v, 0);
    chk("R9 one routed pulse", pcnt[4] - p0, 1);
    chk("R9 tick not routed", pcnt[0], 0);

    // R6: writing one does not clear; zero does
    wr_reg(12'h148, 1);
    rd_reg(12'h148, v); chk("R6 write one keeps event", v, 1);
    wr_reg(12'h148, 0);
    rd_reg(12'h148, v); chk("R6 write zero clears", v, 0);

    done = 1;
    finish_up();
  end
endmodule